// File: doc/BRIEF.md
# Low-Priority Minimum-Tenure Arbiter

This block arbitrates one shared bus between three requesters: a low-priority transfer owner, a group of other agents seen as one request line, and a high-priority requester. When the low-priority owner gains the bus it gets a guaranteed slice of ownership. The slice length comes from an 8-bit control register whose upper five bits count in units of eight clocks. The slice spans back-to-back low-priority transactions of the same direction. A change of direction (read to write or back) starts a new phase and restarts the slice. A high-priority request takes the bus on the next clock no matter what the timer holds. A control value of zero switches the minimum tenure off, so the bus can be handed over at any transaction boundary.

The arbiter is a four-state machine. In `ST_IDLE` nobody owns the bus. In `ST_LOW` the low-priority owner holds it under the slice timer. `ST_OTHER` gives the bus to the other agents and `ST_HIGH` gives it to the high-priority requester. These transitions are named:

- Idle-to-low: the low-priority request is pending.
- Idle-to-other: only the other-agent request is pending.
- Any-to-high: the high-priority request is present. This transition beats every other one.
- Low-to-other on expiry: the slice has run out and another agent is waiting.
- Low-to-other or low-to-idle on release: the owner drops its request.
- Other-to-low or other-to-idle on release: the other agents drop their request.
- High-to-low or high-to-other on release: the high-priority request ends. The low-priority request is preferred.

The slice timer loads on the first clock of each low-priority phase and counts down while that phase holds the bus. A status output goes high in the last guaranteed cycle and stays high until the phase ends.

Top module: `lp_tenure_arbiter`

## Requirements
- R1: After reset the control register reads 00h, all three grants are low and `slice_done` is low.
- R2: A write stores `cfg_wdata` with bits 2:0 forced to zero. `cfg_rdata` shows the stored value from the clock after the write.
- R3: From idle, a low-priority request raises `gnt_low` one clock later, even when the other-agent request is also pending.
- R4: With control value V nonzero, and with the low-priority and other-agent requests both held, `gnt_low` stays high for exactly V clocks (V is a multiple of 8). `gnt_other` rises on the clock after that.
- R5: `slice_done` is low in the first V-1 cycles of a low-priority phase and high in cycle V.
- R6: After the slice expires with no other request pending, the owner keeps `gnt_low`. A later other-agent request moves the grant one clock after it appears.
- R7: A high-priority request raises `gnt_high`, and drops any other grant, one clock later, even before the slice expires.
- R8: With control value 00h, `slice_done` is high in the first cycle of the phase, and a pending other-agent request takes the bus on the next clock.
- R9: A change of `low_is_write` during ownership starts a new phase on the next clock. That new phase is again guaranteed V clocks.
- R10: A register write during a phase leaves that phase's slice length unchanged. The new value applies from the next phase.
- R11: When the low-priority owner drops its request, the bus moves one clock later, to the other agents if they are requesting and to idle otherwise.
- R12: The other agents keep the bus while they request it. After they release it, a pending low-priority request is granted one clock later.
- R13: When the high-priority request ends with both other requests pending, the low-priority owner is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| low_req | input | 1 | Low-priority owner requests the bus |
| low_is_write | input | 1 | Direction of the current low-priority transaction (1 = write) |
| other_req | input | 1 | Another agent requests the bus |
| high_req | input | 1 | High-priority request |
| gnt_low | output | 1 | Bus granted to the low-priority owner |
| gnt_other | output | 1 | Bus granted to the other agents |
| gnt_high | output | 1 | Bus granted to the high-priority requester |
| slice_done | output | 1 | The guaranteed slice of the current low-priority phase has expired |

## Verification
The bench first aims at the slice boundary. If the timer is off by one, the grant moves a cycle early or late against the expected V-cycle window, and `slice_done` rises in the wrong cycle. A direction change halfway through the slice is driven so that a design which fails to reload would hand the bus over at the old expiry point. The bench also writes a new length during a phase: a design that reads the register live would shorten the running slice. Further cases cover a zero setting, where a broken disable would hold the bus for a full slice, and a high-priority request before expiry, where a design that waits on the timer would delay `gnt_high`.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_OTHER = 2'd2,
        ST_HIGH  = 2'd3
    } own_state_t;
endpackage

// File: rtl/tenure_cfg_reg.sv
module tenure_cfg_reg #(
    parameter int CFG_W     = 8,
    parameter int GRAN_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] value
);
    localparam logic [CFG_W-1:0] KEEP_MASK =
        {{(CFG_W-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

    logic [CFG_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (we) begin
            value_q <= wdata & KEEP_MASK;
        end
    end

    assign value = value_q;

    // R2: read-back after a write carries the written bits, low field cleared
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (value == ($past(wdata) & KEEP_MASK)));
endmodule

// File: rtl/tenure_slice_timer.sv
module tenure_slice_timer #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic [CFG_W-1:0] len_in,
    output logic             expired
);
    localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

    logic [CFG_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= (len_in == '0) ? '0 : (len_in - ONE);
        end else if (active && (remain_q != '0)) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign expired = active && (remain_q == '0);

    // R5: an unexpired running slice moves one step closer to expiry per clock
    a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && !expired) |=> (remain_q == $past(remain_q) - ONE));

    // R10: a fresh phase never starts already past a nonzero slice
    a_r10_load_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (len_in > ONE)) |=> (remain_q == $past(len_in) - ONE));
endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
    import tenure_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_req,
    input  logic       low_is_write,
    input  logic       other_req,
    input  logic       high_req,
    input  logic       expired,
    output own_state_t state,
    output logic       phase_start,
    output logic       gnt_low,
    output logic       gnt_other,
    output logic       gnt_high
);
    own_state_t state_q;
    own_state_t state_d;
    logic       phase_wr_q;
    logic       dir_change;

    assign dir_change = (state_q == ST_LOW) && low_req && (low_is_write != phase_wr_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (high_req)       state_d = ST_HIGH;
                else if (low_req)   state_d = ST_LOW;
                else if (other_req) state_d = ST_OTHER;
            end
            ST_LOW: begin
                if (high_req)                     state_d = ST_HIGH;
                else if (!low_req)                state_d = other_req ? ST_OTHER : ST_IDLE;
                else if (other_req && expired)    state_d = ST_OTHER;
            end
            ST_OTHER: begin
                if (high_req)        state_d = ST_HIGH;
                else if (!other_req) state_d = low_req ? ST_LOW : ST_IDLE;
            end
            ST_HIGH: begin
                if (!high_req) begin
                    if (low_req)        state_d = ST_LOW;
                    else if (other_req) state_d = ST_OTHER;
                    else                state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign phase_start = (state_d == ST_LOW) && ((state_q != ST_LOW) || dir_change);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (phase_start) phase_wr_q <= low_is_write;
        end
    end

    always_comb begin
        gnt_low   = 1'b0;
        gnt_other = 1'b0;
        gnt_high  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOW:   gnt_low   = 1'b1;
            ST_OTHER: gnt_other = 1'b1;
            ST_HIGH:  gnt_high  = 1'b1;
            default:  ;
        endcase
    end

    assign state = state_q;

    // R3: idle with a low-priority request hands the bus to that owner
    a_r3_idle_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && low_req && !high_req) |=> gnt_low);

    // R12: the other agents are not displaced while they still request
    a_r12_other_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_other && other_req && !high_req) |=> gnt_other);
endmodule

// File: rtl/lp_tenure_arbiter.sv
module lp_tenure_arbiter
    import tenure_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int GRAN_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             low_req,
    input  logic             low_is_write,
    input  logic             other_req,
    input  logic             high_req,
    output logic             gnt_low,
    output logic             gnt_other,
    output logic             gnt_high,
    output logic             slice_done
);
    logic [CFG_W-1:0] slice_len;
    logic             phase_start;
    logic             expired;
    own_state_t       state;

    tenure_cfg_reg #(.CFG_W(CFG_W), .GRAN_BITS(GRAN_BITS)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .value (slice_len)
    );

    tenure_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_req      (low_req),
        .low_is_write (low_is_write),
        .other_req    (other_req),
        .high_req     (high_req),
        .expired      (expired),
        .state        (state),
        .phase_start  (phase_start),
        .gnt_low      (gnt_low),
        .gnt_other    (gnt_other),
        .gnt_high     (gnt_high)
    );

    tenure_slice_timer #(.CFG_W(CFG_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (phase_start),
        .active  (state == ST_LOW),
        .len_in  (slice_len),
        .expired (expired)
    );

    assign cfg_rdata  = slice_len;
    assign slice_done = expired;

    // R3: at most one grant at any time
    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_low, gnt_other, gnt_high}));

    // R7: high priority wins the next clock regardless of the slice
    a_r7_high_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
        high_req |=> gnt_high);

    // R4: no loss of the bus before expiry while the owner still requests
    a_r4_hold_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_low && low_req && !high_req && !slice_done) |=> gnt_low);

    // R4: expiry with a waiting agent moves the bus
    a_r4_handoff_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_low && slice_done && low_req && other_req && !high_req) |=> gnt_other);

    // R6: expiry with nobody waiting keeps the owner
    a_r6_keep_when_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_low && slice_done && low_req && !other_req && !high_req) |=> gnt_low);
endmodule

// File: tb/test_lp_tenure_arbiter.sv
module test_lp_tenure_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int          cyc;
        logic [2:0]  gnt;
        int          done;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       low_req = 1'b0;
    logic       low_is_write = 1'b0;
    logic       other_req = 1'b0;
    logic       high_req = 1'b0;
    logic       gnt_low, gnt_other, gnt_high, slice_done;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t sb[$];

    lp_tenure_arbiter i_lp_tenure_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .low_req      (low_req),
        .low_is_write (low_is_write),
        .other_req    (other_req),
        .high_req     (high_req),
        .gnt_low      (gnt_low),
        .gnt_other    (gnt_other),
        .gnt_high     (gnt_high),
        .slice_done   (slice_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(int off, logic [2:0] g, int d, string tag);
        exp_t e;
        e.cyc = cyc + off; e.gnt = g; e.done = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic release_all();
        low_req = 1'b0; other_req = 1'b0; high_req = 1'b0;
        step(2);
    endtask

    // scoreboard monitor: compares every item due in this cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    check({gnt_high, gnt_other, gnt_low} == sb[i].gnt,
                          {sb[i].tag, " grants"},
                          {gnt_high, gnt_other, gnt_low}, sb[i].gnt);
                    if (sb[i].done >= 0)
                        check(slice_done == sb[i].done[0],
                              {sb[i].tag, " slice_done"}, slice_done, sb[i].done);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check(cfg_rdata == 8'h00, "R1 reg", cfg_rdata, 0);
        check({gnt_high, gnt_other, gnt_low} == 3'b000, "R1 grants",
              {gnt_high, gnt_other, gnt_low}, 0);
        check(slice_done == 1'b0, "R1 slice_done", slice_done, 0);

        // R2 read-back with low bits cleared
        cfg_write(8'h17);
        check(cfg_rdata == 8'h10, "R2 readback", cfg_rdata, 8'h10);
        cfg_write(8'hFF);
        check(cfg_rdata == 8'hF8, "R2 readback", cfg_rdata, 8'hF8);
        cfg_write(8'h10);
        step(1);

        // R3/R4/R5: both requests from idle, 16-cycle slice
        low_req = 1'b1; other_req = 1'b1;
        expect_at(1, 3'b001, 0, "R3");
        for (int k = 2; k <= 16; k++)
            expect_at(k, 3'b001, (k == 16) ? 1 : 0, "R4_R5");
        expect_at(17, 3'b010, 0, "R4");
        expect_at(18, 3'b010, 0, "R12");
        step(18);
        // R12: other releases, low regains
        other_req = 1'b0;
        expect_at(1, 3'b001, 0, "R12");
        expect_at(16, 3'b001, 1, "R6");
        expect_at(20, 3'b001, 1, "R6");
        step(20);
        other_req = 1'b1;
        expect_at(1, 3'b010, 0, "R6");
        step(2);
        low_req = 1'b0; other_req = 1'b0;
        expect_at(1, 3'b000, 0, "R11");
        step(2);

        // R7/R13: high preempts mid-slice, then low preferred
        low_req = 1'b1;
        step(3);
        high_req = 1'b1; other_req = 1'b1;
        expect_at(1, 3'b100, 0, "R7");
        expect_at(2, 3'b100, 0, "R7");
        step(2);
        high_req = 1'b0;
        expect_at(1, 3'b001, 0, "R13");
        step(2);
        release_all();

        // R8: zero disables the slice
        cfg_write(8'h00);
        step(1);
        low_req = 1'b1; other_req = 1'b1;
        expect_at(1, 3'b001, 1, "R8");
        expect_at(2, 3'b010, 0, "R8");
        step(3);
        release_all();

        // R9: direction change reloads the slice
        cfg_write(8'h10);
        step(1);
        low_req = 1'b1; low_is_write = 1'b0;
        step(10);
        low_is_write = 1'b1; other_req = 1'b1;
        expect_at(7, 3'b001, 0, "R9");
        expect_at(15, 3'b001, 0, "R9");
        expect_at(16, 3'b001, 1, "R9");
        expect_at(17, 3'b010, 0, "R9");
        step(18);
        release_all();
        low_is_write = 1'b0;

        // R10: write during a phase applies from the next phase
        low_req = 1'b1; other_req = 1'b1;
        expect_at(16, 3'b001, 1, "R10");
        expect_at(17, 3'b010, 0, "R10");
        step(4);
        cfg_write(8'h08);
        step(13);
        other_req = 1'b0;
        expect_at(1, 3'b001, 0, "R10");
        step(1);
        other_req = 1'b1;
        expect_at(6, 3'b001, 0, "R10");
        expect_at(7, 3'b001, 1, "R10");
        expect_at(8, 3'b010, 0, "R10");
        step(10);
        release_all();

        // R11: owner drops before expiry, waiting agent takes over
        low_req = 1'b1; other_req = 1'b1;
        step(3);
        low_req = 1'b0;
        expect_at(1, 3'b010, 0, "R11");
        step(2);
        release_all();

        step(3);
        check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        summary();
    end
endmodule